// File: doc/BRIEF.md
# Packet-Terminating Peripheral DMA Channel

This block is one DMA channel that streams a byte buffer from memory into the transmit data register of a serial packet peripheral. The peripheral paces the channel with a request line that stays high while its transmit buffer is empty. The channel stalls whenever that line is low.

Each byte is first read from memory and then written to the peripheral. The final byte of the buffer goes to a separate end-of-frame register address instead of the data address. That write tells the peripheral to close the frame and append its checksum.

Once the frame is closed, the channel reads the peripheral's status register. It stores that byte into a buffer descriptor in memory, at the descriptor base plus a status offset. Both values are captured when the transfer starts. Peripheral strobes are stretched by a programmable wait-state count, and the status read uses the same setting. Software programs the channel through an indexed register write port and learns of completion from a one-cycle done/interrupt pulse.

Top module: `pkt_dma_chan`

## Requirements
- R1: A byte's peripheral write begins only after `req` was seen high in the sampling cycle between bytes. The write strobe rises in the third cycle after that sampling cycle. While `req` stays low, the channel issues no further reads or writes.
- R2: Configuration register indices are as follows: 0 source address, 1 byte count, 2 data register address, 3 end-of-frame register address, 4 status register address, 5 descriptor base, 6 status offset, 7 wait-state count, and 8 control. Writing 1 in bit 0 of the control register starts a transfer.
- R3: Byte i of the transfer is read from memory at source address + i, with `mem_rdata` valid in the cycle after `mem_rd_en`. Every byte except the last is written with its value to the data register address, in ascending order.
- R4: The final byte is written to the end-of-frame register address. This happens exactly once for each transfer whose count is at least 1.
- R5: After the final byte, the channel holds `per_rd` at the status register address and captures `per_rdata` in the last strobe cycle. In the next cycle it issues exactly one `mem_we` that carries that value.
- R6: The status write-back address is the descriptor base plus the status offset, both as they were when the transfer started. Configuration writes made during the transfer do not change it.
- R7: Every `per_wr` strobe and every `per_rd` strobe stays high for exactly 1 + wait-state-count consecutive cycles.
- R8: With a count of 1, the single byte goes straight to the end-of-frame address. With a count of 0, there are no memory or peripheral accesses and no write-back, and done pulses within two cycles of the start write.
- R9: `done` and `irq` rise together for exactly one cycle after the write-back, and `busy` is low in that cycle.
- R10: A byte write already under way runs its full strobe length even if `req` falls during it.
- R11: After reset, `busy`, `done`, `irq`, `per_wr`, `per_rd`, `mem_rd_en` and `mem_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | AW (16) | Configuration write data |
| req | input | 1 | Peripheral transmit buffer empty |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe (status write-back) |
| mem_addr | output | AW (16) | Memory address |
| mem_rdata | input | DW (8) | Memory read data, one cycle after read strobe |
| mem_wdata | output | DW (8) | Memory write data |
| per_wr | output | 1 | Peripheral register write strobe |
| per_rd | output | 1 | Peripheral register read strobe |
| per_addr | output | PAW (8) | Peripheral register address |
| per_wdata | output | DW (8) | Peripheral write data |
| per_rdata | input | DW (8) | Peripheral read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The properties assume that the data and end-of-frame register addresses differ, since otherwise a final write could not be told apart from an ordinary one. They also assume that memory returns read data exactly one cycle after the strobe and that `per_rdata` is steady while `per_rd` is high.

The bench memory model answers on the falling edge after each read strobe. The peripheral model drives the status value only while the status address is selected. It holds the request low for a fixed number of cycles after every write, so a request that falls in the middle of a byte is exercised. All transfers use three fixed, distinct peripheral addresses.

// File: rtl/pkt_dma_pkg.sv
package pkt_dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_RD,
    S_CAP,
    S_WR,
    S_SRD,
    S_SWB,
    S_FIN
  } seq_state_t;

  localparam int unsigned IDX_SRC  = 0;
  localparam int unsigned IDX_CNT  = 1;
  localparam int unsigned IDX_DATA = 2;
  localparam int unsigned IDX_LAST = 3;
  localparam int unsigned IDX_STAT = 4;
  localparam int unsigned IDX_DESC = 5;
  localparam int unsigned IDX_OFF  = 6;
  localparam int unsigned IDX_WAIT = 7;
  localparam int unsigned IDX_GO   = 8;
  localparam int unsigned IDX_W    = 4;

endpackage

// File: rtl/pkt_dma_regs.sv
module pkt_dma_regs
  import pkt_dma_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned PAW = 8,
  parameter int unsigned WW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     cnt_o,
  output logic [PAW-1:0]    data_a_o,
  output logic [PAW-1:0]    last_a_o,
  output logic [PAW-1:0]    stat_a_o,
  output logic [AW-1:0]     desc_o,
  output logic [AW-1:0]     off_o,
  output logic [WW-1:0]     wait_o,
  output logic              go_o
);

  logic [AW-1:0]  src_q, cnt_q, desc_q, off_q;
  logic [PAW-1:0] data_a_q, last_a_q, stat_a_q;
  logic [WW-1:0]  wait_q;
  logic           go_q, go_d;
  logic           unused_hi;

  assign unused_hi = ^cfg_wdata;

  function automatic logic hit(input logic [IDX_W-1:0] i, input int unsigned n);
    return cfg_we && (i == IDX_W'(n));
  endfunction

  assign go_d = hit(cfg_idx, IDX_GO) && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      cnt_q    <= '0;
      desc_q   <= '0;
      off_q    <= '0;
      data_a_q <= '0;
      last_a_q <= '0;
      stat_a_q <= '0;
      wait_q   <= '0;
      go_q     <= 1'b0;
    end else begin
      if (hit(cfg_idx, IDX_SRC))  src_q    <= cfg_wdata;
      if (hit(cfg_idx, IDX_CNT))  cnt_q    <= cfg_wdata;
      if (hit(cfg_idx, IDX_DESC)) desc_q   <= cfg_wdata;
      if (hit(cfg_idx, IDX_OFF))  off_q    <= cfg_wdata;
      if (hit(cfg_idx, IDX_DATA)) data_a_q <= cfg_wdata[PAW-1:0];
      if (hit(cfg_idx, IDX_LAST)) last_a_q <= cfg_wdata[PAW-1:0];
      if (hit(cfg_idx, IDX_STAT)) stat_a_q <= cfg_wdata[PAW-1:0];
      if (hit(cfg_idx, IDX_WAIT)) wait_q   <= cfg_wdata[WW-1:0];
      go_q <= go_d;
    end
  end

  assign src_o    = src_q;
  assign cnt_o    = cnt_q;
  assign desc_o   = desc_q;
  assign off_o    = off_q;
  assign data_a_o = data_a_q;
  assign last_a_o = last_a_q;
  assign stat_a_o = stat_a_q;
  assign wait_o   = wait_q;
  assign go_o     = go_q;

endmodule

// File: rtl/pkt_dma_timer.sv
module pkt_dma_timer #(
  parameter int unsigned WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [WW-1:0] limit,
  output logic          last
);

  logic [WW-1:0] cnt_q, cnt_d;
  logic          en;

  assign last = run && (cnt_q == limit);
  assign en   = run || (cnt_q != '0);

  always_comb begin
    if (!run || last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pkt_dma_seq.sv
module pkt_dma_seq
  import pkt_dma_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned PAW = 8,
  parameter int unsigned DW  = 8,
  parameter int unsigned WW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_cnt,
  input  logic [PAW-1:0] cfg_data_a,
  input  logic [PAW-1:0] cfg_last_a,
  input  logic [PAW-1:0] cfg_stat_a,
  input  logic [AW-1:0]  cfg_desc,
  input  logic [AW-1:0]  cfg_off,
  input  logic [WW-1:0]  cfg_wait,
  input  logic           req,
  input  logic [DW-1:0]  mem_rdata,
  input  logic [DW-1:0]  per_rdata,
  input  logic           t_last,
  output logic           t_run,
  output logic           mem_rd_en,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           per_wr,
  output logic           per_rd,
  output logic [PAW-1:0] per_addr,
  output logic [DW-1:0]  per_wdata,
  output logic           busy,
  output logic           done,
  output logic [PAW-1:0] lat_data_a,
  output logic [PAW-1:0] lat_last_a,
  output logic [WW-1:0]  lat_wait
);

  seq_state_t     st_q, st_d;
  logic [AW-1:0]  left_q, left_d;
  logic [AW-1:0]  ptr_q, ptr_d;
  logic [AW-1:0]  wb_q;
  logic [PAW-1:0] data_a_q, last_a_q, stat_a_q;
  logic [WW-1:0]  wait_q;
  logic [DW-1:0]  byte_q, stat_q;
  logic           load_en, byte_en, stat_en, cnt_en;
  logic           final_byte;

  assign load_en    = (st_q == S_IDLE) && go;
  assign byte_en    = (st_q == S_CAP);
  assign stat_en    = (st_q == S_SRD) && t_last;
  assign cnt_en     = load_en || byte_en || ((st_q == S_WR) && t_last);
  assign final_byte = (left_q == AW'(1));

  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    ptr_d  = ptr_q;
    unique case (st_q)
      S_IDLE: if (go) begin
        left_d = cfg_cnt;
        ptr_d  = cfg_src;
        st_d   = (cfg_cnt == '0) ? S_FIN : S_REQ;
      end
      S_REQ:  if (req) st_d = S_RD;
      S_RD:   st_d = S_CAP;
      S_CAP: begin
        ptr_d = ptr_q + 1'b1;
        st_d  = S_WR;
      end
      S_WR: if (t_last) begin
        left_d = left_q - 1'b1;
        st_d   = final_byte ? S_SRD : S_REQ;
      end
      S_SRD:  if (t_last) st_d = S_SWB;
      S_SWB:  st_d = S_FIN;
      S_FIN:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      ptr_q  <= '0;
    end else if (cnt_en) begin
      left_q <= left_d;
      ptr_q  <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q     <= '0;
      data_a_q <= '0;
      last_a_q <= '0;
      stat_a_q <= '0;
      wait_q   <= '0;
    end else if (load_en) begin
      wb_q     <= cfg_desc + cfg_off;
      data_a_q <= cfg_data_a;
      last_a_q <= cfg_last_a;
      stat_a_q <= cfg_stat_a;
      wait_q   <= cfg_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (byte_en) byte_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= per_rdata;
  end

  always_comb begin
    mem_rd_en = (st_q == S_RD);
    mem_we    = (st_q == S_SWB);
    mem_addr  = (st_q == S_SWB) ? wb_q : ptr_q;
    mem_wdata = stat_q;
    per_wr    = (st_q == S_WR);
    per_rd    = (st_q == S_SRD);
    per_wdata = byte_q;
    if (st_q == S_SRD)   per_addr = stat_a_q;
    else if (final_byte) per_addr = last_a_q;
    else                 per_addr = data_a_q;
    t_run = per_wr || per_rd;
    busy  = (st_q != S_IDLE) && (st_q != S_FIN);
    done  = (st_q == S_FIN);
  end

  assign lat_data_a = data_a_q;
  assign lat_last_a = last_a_q;
  assign lat_wait   = wait_q;

endmodule

// File: rtl/pkt_dma_chan.sv
module pkt_dma_chan
  import pkt_dma_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned PAW = 8,
  parameter int unsigned DW  = 8,
  parameter int unsigned WW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             req,
  output logic             mem_rd_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    mem_wdata,
  output logic             per_wr,
  output logic             per_rd,
  output logic [PAW-1:0]   per_addr,
  output logic [DW-1:0]    per_wdata,
  input  logic [DW-1:0]    per_rdata,
  output logic             busy,
  output logic             done,
  output logic             irq
);

  logic           rst_s1, rst_ns;
  logic [AW-1:0]  c_src, c_cnt, c_desc, c_off;
  logic [PAW-1:0] c_data_a, c_last_a, c_stat_a;
  logic [WW-1:0]  c_wait;
  logic           c_go;
  logic           t_run, t_last;
  logic [PAW-1:0] lat_data_a, lat_last_a;
  logic [WW-1:0]  lat_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ns <= rst_s1;
    end
  end

  pkt_dma_regs #(.AW(AW), .PAW(PAW), .WW(WW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_ns),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_wdata(cfg_wdata),
    .src_o    (c_src),
    .cnt_o    (c_cnt),
    .data_a_o (c_data_a),
    .last_a_o (c_last_a),
    .stat_a_o (c_stat_a),
    .desc_o   (c_desc),
    .off_o    (c_off),
    .wait_o   (c_wait),
    .go_o     (c_go)
  );

  pkt_dma_timer #(.WW(WW)) u_timer (
    .clk  (clk),
    .rst_n(rst_ns),
    .run  (t_run),
    .limit(lat_wait),
    .last (t_last)
  );

  pkt_dma_seq #(.AW(AW), .PAW(PAW), .DW(DW), .WW(WW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_ns),
    .go        (c_go),
    .cfg_src   (c_src),
    .cfg_cnt   (c_cnt),
    .cfg_data_a(c_data_a),
    .cfg_last_a(c_last_a),
    .cfg_stat_a(c_stat_a),
    .cfg_desc  (c_desc),
    .cfg_off   (c_off),
    .cfg_wait  (c_wait),
    .req       (req),
    .mem_rdata (mem_rdata),
    .per_rdata (per_rdata),
    .t_last    (t_last),
    .t_run     (t_run),
    .mem_rd_en (mem_rd_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .per_wr    (per_wr),
    .per_rd    (per_rd),
    .per_addr  (per_addr),
    .per_wdata (per_wdata),
    .busy      (busy),
    .done      (done),
    .lat_data_a(lat_data_a),
    .lat_last_a(lat_last_a),
    .lat_wait  (lat_wait)
  );

  assign irq = done;

endmodule

// File: rtl/pkt_dma_chan_chk.sv
module pkt_dma_chan_chk #(
  parameter int unsigned PAW = 8,
  parameter int unsigned WW  = 4
) (
  input logic           clk,
  input logic           rst_ns,
  input logic           req,
  input logic           per_wr,
  input logic           per_rd,
  input logic [PAW-1:0] per_addr,
  input logic           mem_we,
  input logic           busy,
  input logic           done,
  input logic           irq,
  input logic [PAW-1:0] lat_data_a,
  input logic [PAW-1:0] lat_last_a,
  input logic [WW-1:0]  lat_wait
);

  logic [WW:0] run_wr, run_rd;
  logic [1:0]  last_cnt;
  logic        wr_d, busy_d;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      run_wr   <= '0;
      run_rd   <= '0;
      last_cnt <= '0;
      wr_d     <= 1'b0;
      busy_d   <= 1'b0;
    end else begin
      run_wr <= per_wr ? run_wr + 1'b1 : '0;
      run_rd <= per_rd ? run_rd + 1'b1 : '0;
      wr_d   <= per_wr;
      busy_d <= busy;
      if (busy && !busy_d)
        last_cnt <= '0;
      else if (per_wr && !wr_d && per_addr == lat_last_a && last_cnt != 2'd3)
        last_cnt <= last_cnt + 1'b1;
    end
  end

  p_req_gate_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(per_wr) |-> $past(req, 3));

  p_wr_target_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    per_wr |-> (per_addr == lat_data_a || per_addr == lat_last_a));

  p_last_once_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> last_cnt <= 2'd1);

  p_wb_after_status_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(mem_we) |-> $past(per_rd));

  p_wr_len_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(per_wr) |-> run_wr == {1'b0, lat_wait} + 1'b1);

  p_rd_len_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(per_rd) |-> run_rd == {1'b0, lat_wait} + 1'b1);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> (!busy && irq));

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    !(per_wr && per_rd));

endmodule

bind pkt_dma_chan pkt_dma_chan_chk #(.PAW(PAW), .WW(WW)) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .req       (req),
  .per_wr    (per_wr),
  .per_rd    (per_rd),
  .per_addr  (per_addr),
  .mem_we    (mem_we),
  .busy      (busy),
  .done      (done),
  .irq       (irq),
  .lat_data_a(lat_data_a),
  .lat_last_a(lat_last_a),
  .lat_wait  (lat_wait)
);

// File: tb/pkt_dma_chan_bench.sv
module pkt_dma_chan_bench;

  localparam int AW = 16;
  localparam int PAW = 8;
  localparam int DW = 8;
  localparam int WW = 4;
  localparam logic [7:0] A_DATA = 8'h30;
  localparam logic [7:0] A_LAST = 8'h31;
  localparam logic [7:0] A_STAT = 8'h32;

  logic clk, rst_n;
  logic cfg_we;
  logic [3:0] cfg_idx;
  logic [AW-1:0] cfg_wdata;
  logic req;
  logic mem_rd_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, mem_wdata;
  logic per_wr, per_rd;
  logic [PAW-1:0] per_addr;
  logic [DW-1:0] per_wdata, per_rdata;
  logic busy, done, irq;

  int tests, fails, cyc;

  pkt_dma_chan u_pkt_dma_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req(req), .mem_rd_en(mem_rd_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .per_wr(per_wr), .per_rd(per_rd), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_rdata(per_rdata), .busy(busy), .done(done),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] fmem(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8];
  endfunction

  // bench-side models and monitor state
  int tx_cnt, cur_d, cur_wait, exp_gap;
  logic [7:0] cur_stat;
  logic [15:0] cur_src;
  int n_wr, n_rd_mem, rd_addr_err, n_wb, n_done, done_bad;
  int strobe_err, rd_strobe_err, gap_err, run_wr, run_rd, low_run;
  bit seen_wr, prev_wr, prev_rd, prev_done;
  logic [7:0] wr_a [0:7];
  logic [7:0] wr_d [0:7];
  logic [15:0] wb_addr;
  logic [7:0] wb_data;

  assign req = (tx_cnt == 0);

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (per_wr) begin
        if (!prev_wr) begin
          if (n_wr < 8) begin
            wr_a[n_wr] = per_addr;
            wr_d[n_wr] = per_wdata;
          end
          n_wr++;
          if (seen_wr && low_run != exp_gap) gap_err++;
        end
        run_wr++;
        tx_cnt = cur_d;
      end else begin
        if (prev_wr) begin
          if (run_wr != cur_wait + 1) strobe_err++;
          run_wr = 0;
          low_run = 0;
          seen_wr = 1;
        end
        low_run++;
        if (tx_cnt > 0) tx_cnt--;
      end
      if (per_rd) begin
        run_rd++;
        per_rdata = (per_addr == A_STAT) ? cur_stat : 8'h00;
      end else begin
        if (prev_rd && run_rd != cur_wait + 1) rd_strobe_err++;
        run_rd = 0;
      end
      if (mem_rd_en) begin
        if (mem_addr != cur_src + 16'(n_rd_mem)) rd_addr_err++;
        mem_rdata = fmem(mem_addr);
        n_rd_mem++;
      end
      if (mem_we) begin
        n_wb++;
        wb_addr = mem_addr;
        wb_data = mem_wdata;
      end
      if (done) begin
        n_done++;
        if (busy || !irq || prev_done) done_bad++;
      end
      if (irq && !done) done_bad++;
      prev_wr = per_wr;
      prev_rd = per_rd;
      prev_done = done;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic cfg_write(input int idx, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_idx = 4'(idx);
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_xfer(input int t, input int count, input int wt, input int d);
    logic [15:0] desc, off;
    int start_cyc, waited;
    desc = 16'h4000 + 16'(t * 4);
    off = 16'(3 + (t % 4));
    cur_src = 16'h0200 + 16'(t * 16);
    cur_d = d;
    cur_wait = wt;
    exp_gap = (d + 2 > 3) ? d + 2 : 3;
    cur_stat = 8'hA0 ^ 8'(t);
    n_wr = 0; n_rd_mem = 0; rd_addr_err = 0; n_wb = 0; n_done = 0;
    done_bad = 0; strobe_err = 0; rd_strobe_err = 0; gap_err = 0;
    seen_wr = 0; low_run = 0;
    cfg_write(0, cur_src);
    cfg_write(1, 16'(count));
    cfg_write(2, {8'h00, A_DATA});
    cfg_write(3, {8'h00, A_LAST});
    cfg_write(4, {8'h00, A_STAT});
    cfg_write(5, desc);
    cfg_write(6, off);
    cfg_write(7, 16'(wt));
    start_cyc = cyc;
    cfg_write(8, 16'h0001);
    // change descriptor base while running: must not affect write-back (R6)
    cfg_write(5, 16'hBEEF);
    cfg_write(6, 16'h0077);
    waited = 0;
    while (n_done == 0 && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    repeat (3) @(negedge clk);
    check(n_done == 1, "R9 done count", n_done, 1);
    check(done_bad == 0, "R9 done/irq pulse with busy low", done_bad, 0);
    check(strobe_err == 0 && rd_strobe_err == 0, "R7 strobe length",
          strobe_err + rd_strobe_err, 0);
    if (count == 0) begin
      check(n_wr == 0 && n_rd_mem == 0 && n_wb == 0, "R8 zero count no access",
            n_wr + n_rd_mem + n_wb, 0);
      check(waited <= 3, "R8 zero count done latency", waited, 3);
    end else begin
      int bad;
      bad = 0;
      for (int i = 0; i < count; i++) begin
        logic [7:0] ea;
        ea = (i == count - 1) ? A_LAST : A_DATA;
        if (wr_a[i] != ea || wr_d[i] != fmem(cur_src + 16'(i))) bad++;
      end
      check(n_rd_mem == count && rd_addr_err == 0, "R3 memory read order",
            n_rd_mem, count);
      check(n_wr == count && bad == 0, "R3 data bytes to data address", bad, 0);
      check(wr_a[count-1] == A_LAST, "R4 final byte to end-of-frame address",
            int'(wr_a[count-1]), int'(A_LAST));
      if (count == 1)
        check(wr_a[0] == A_LAST, "R8 single byte to end-of-frame", int'(wr_a[0]),
              int'(A_LAST));
      check(n_wb == 1 && wb_data == cur_stat, "R5 status write-back value",
            int'(wb_data), int'(cur_stat));
      check(wb_addr == desc + off, "R6 write-back at start-time descriptor",
            int'(wb_addr), int'(desc + off));
      if (count >= 2)
        check(gap_err == 0, "R1 request pacing gap", gap_err, 0);
      if (d > 0)
        check(n_wr == count, "R10 byte completes after request drop", n_wr, count);
    end
    if (start_cyc < 0) $display("unreachable");
  endtask

  initial begin
    tests = 0; fails = 0; cyc = 0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    mem_rdata = '0; per_rdata = '0;
    tx_cnt = 0; cur_d = 0; cur_wait = 0; exp_gap = 3; cur_stat = '0; cur_src = '0;
    prev_wr = 0; prev_rd = 0; prev_done = 0; run_wr = 0; run_rd = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !irq && !per_wr && !per_rd && !mem_rd_en && !mem_we,
          "R11 reset state",
          int'({busy, done, irq, per_wr, per_rd, mem_rd_en, mem_we}), 0);
    // R2 register map is exercised by every transfer below
    begin
      int t;
      t = 0;
      for (int d = 0; d <= 4; d += 4)
        for (int wt = 0; wt <= 2; wt++)
          for (int c = 0; c <= 5; c++) begin
            run_xfer(t, c, wt, d);
            t++;
          end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule